// File: doc/BRIEF.md
# Elastic Rate Match Buffer

This block is a dual-clock elastic store for 9-bit receive symbols. Each symbol has eight data bits and a ninth bit that marks a control character. Symbols are written in a recovered receive clock domain and read in a local clock domain. Every enabled read produces one symbol and a 3-bit receive status code.

When the two clocks drift apart, the block compensates using skip symbols (9'h11C). It drops a skip symbol when the fill level is above a programmable high mark. It plays a skip symbol twice when the fill level is below a programmable low mark.

If a read finds the store empty, the block does not stall and does not repeat old data. It emits the error control character 9'h1FE and reports an underflow code in that same cycle. Real data then resumes in order as soon as it arrives. A configuration input selects a zero-ppm mode for synchronous systems; in that mode no skip symbol is ever added or removed.

Top module: `elastic_rate_match`

## Requirements
- R1: Data symbols (bit 8 = 0) are read out in exactly the order written. None is lost or duplicated unless it was discarded by R5.
- R2: After reset the read outputs are 9'h11C with status 3'b000, and the store holds DEPTH/2 skip symbols. With zero-ppm mode on and no writes, the first DEPTH/2 reads therefore return 9'h11C.
- R3: An enabled read that finds the store empty outputs 9'h1FE. Its status is 3'b110 if it is the first empty read since reset or since the last non-empty read; otherwise the status is 3'b000.
- R4: Status 3'b110 appears only in a cycle whose output symbol is 9'h1FE, and never in two consecutive read-out cycles.
- R5: A write while the store holds DEPTH entries is discarded. The next non-empty read reports status 3'b101 with its symbol, and no skip add or drop happens on that read.
- R6: With zero-ppm off, a non-empty read where the level is above hi_wm_i (and at least 2) and the head is 9'h11C removes that skip symbol. The following symbol is output with status 3'b010.
- R7: With zero-ppm off, a read where the level is below lo_wm_i and the head is 9'h11C outputs the skip symbol with status 3'b001 and does not consume it. The next read consumes it with status 3'b000, so no skip is repeated twice in a row.
- R8: With zero_ppm_i high, no skip symbol is added or removed, and status never reads 3'b010 or 3'b001.
- R9: While rd_en_i is low, rd_sym_o holds its value and rd_status_o reads 3'b000.
- R10: Any read without an event reports status 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr_i | input | 1 | Recovered receive clock |
| rst_wr_ni | input | 1 | Active-low async reset, write domain |
| wr_en_i | input | 1 | Write strobe |
| wr_sym_i | input | 9 | Symbol to write; bit 8 marks a control character |
| clk_rd_i | input | 1 | Local read clock |
| rst_rd_ni | input | 1 | Active-low async reset, read domain |
| rd_en_i | input | 1 | Read strobe |
| zero_ppm_i | input | 1 | 1: no clock compensation |
| hi_wm_i | input | AW+1 | Level above which a skip is dropped |
| lo_wm_i | input | AW+1 | Level below which a skip is repeated |
| rd_sym_o | output | 9 | Symbol read out |
| rd_status_o | output | 3 | Receive status code for rd_sym_o |

## Verification
Read results are registered, so each one appears on the clock edge that samples rd_en_i high. The monitor records rd_en_i at every read-clock rising edge and judges the outputs at the following falling edge. Events that cross clock domains need two or three cycles to take effect: a written symbol raising the level, a full store seen by the writer, and an overflow flag reaching the reader. The bench therefore waits at least ten cycles after each write burst before it enables reads. It then checks totals: skips seen, drops, inserts, underflows and overflows per phase. These are the quantities the thresholds fix exactly.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam logic [8:0] SYM_SKP = 9'h11C;
  localparam logic [8:0] SYM_UF  = 9'h1FE;

  typedef enum logic [2:0] {
    ST_OK   = 3'b000,
    ST_INS  = 3'b001,
    ST_DROP = 3'b010,
    ST_OVF  = 3'b101,
    ST_UF   = 3'b110
  } rx_status_e;

  function automatic logic [31:0] gray_of(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] bin_of(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/rmf_rst_sync.sv
module rmf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= 2'b00;
    else         sr_q <= {sr_q[0], 1'b1};
  end
  assign rst_no = sr_q[1];
endmodule

// File: rtl/rmf_sync.sv
module rmf_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] m_q, s_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= RST_VAL;
      s_q <= RST_VAL;
    end else begin
      m_q <= d_i;
      s_q <= m_q;
    end
  end
  assign q_o = s_q;
endmodule

// File: rtl/rmf_wr_ctl.sv
module rmf_wr_ctl
  import rmf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [8:0]                       wr_sym_i,
  input  logic [$clog2(DEPTH):0]           rgray_sync_i,
  output logic [$clog2(DEPTH):0]           wgray_o,
  output logic                             ovf_tgl_o,
  output logic [DEPTH-1:0][8:0]            mem_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]         wbin_q, wgray_q, rbin_s, wbin_inc;
  logic [DEPTH-1:0][8:0] mem_q;
  logic                  tgl_q, full;

  assign rbin_s   = PW'(bin_of(32'(rgray_sync_i)));
  assign full     = (wbin_q - rbin_s) == PW'(DEPTH);
  assign wbin_inc = wbin_q + PW'(1);

  // prefilled half full of skip symbols
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= PW'(DEPTH / 2);
      wgray_q <= PW'(gray_of(32'(DEPTH / 2)));
      tgl_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= SYM_SKP;
    end else if (wr_en_i) begin
      if (full) begin
        tgl_q <= ~tgl_q;
      end else begin
        mem_q[wbin_q[AW-1:0]] <= wr_sym_i;
        wbin_q  <= wbin_inc;
        wgray_q <= PW'(gray_of(32'(wbin_inc)));
      end
    end
  end

  assign wgray_o   = wgray_q;
  assign ovf_tgl_o = tgl_q;
  assign mem_o     = mem_q;

  // R5
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full) |=> $stable(wbin_q));
endmodule

// File: rtl/rmf_rd_ctl.sv
module rmf_rd_ctl
  import rmf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_en_i,
  input  logic                    zero_ppm_i,
  input  logic [$clog2(DEPTH):0]  hi_wm_i,
  input  logic [$clog2(DEPTH):0]  lo_wm_i,
  input  logic [$clog2(DEPTH):0]  wgray_sync_i,
  input  logic                    ovf_tgl_sync_i,
  input  logic [DEPTH-1:0][8:0]   mem_i,
  output logic [$clog2(DEPTH):0]  rgray_o,
  output logic [8:0]              sym_o,
  output logic [2:0]              status_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s, level;
  logic [AW-1:0] idx0, idx1;
  logic [8:0]    head, nxt, sym_q, sym_d;
  rx_status_e    st_q, st_d;
  logic          uf_q, uf_d, rep_q, rep_d, pend_q, pend_d, tgl_q;
  logic          empty, ovf_evt, do_drop, do_ins;

  assign wbin_s  = PW'(bin_of(32'(wgray_sync_i)));
  assign level   = wbin_s - rbin_q;
  assign empty   = (level == '0);
  assign idx0    = rbin_q[AW-1:0];
  assign idx1    = idx0 + AW'(1);
  assign head    = mem_i[idx0];
  assign nxt     = mem_i[idx1];
  assign ovf_evt = ovf_tgl_sync_i ^ tgl_q;

  assign do_drop = !zero_ppm_i && !pend_q && (head == SYM_SKP) &&
                   (level > hi_wm_i) && (level >= PW'(2));
  assign do_ins  = !zero_ppm_i && !pend_q && !do_drop && (head == SYM_SKP) &&
                   (level < lo_wm_i) && !rep_q;

  always_comb begin
    rbin_d = rbin_q;
    sym_d  = sym_q;
    st_d   = ST_OK;
    uf_d   = uf_q;
    rep_d  = rep_q;
    pend_d = pend_q | ovf_evt;
    if (rd_en_i) begin
      if (empty) begin
        sym_d = SYM_UF;
        st_d  = uf_q ? ST_OK : ST_UF;
        uf_d  = 1'b1;
        rep_d = 1'b0;
      end else begin
        uf_d  = 1'b0;
        rep_d = 1'b0;
        if (pend_q) begin
          sym_d  = head;
          st_d   = ST_OVF;
          rbin_d = rbin_q + PW'(1);
          pend_d = ovf_evt;
        end else if (do_drop) begin
          sym_d  = nxt;
          st_d   = ST_DROP;
          rbin_d = rbin_q + PW'(2);
        end else if (do_ins) begin
          sym_d = head;
          st_d  = ST_INS;
          rep_d = 1'b1;
        end else begin
          sym_d  = head;
          rbin_d = rbin_q + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      sym_q   <= SYM_SKP;
      st_q    <= ST_OK;
      uf_q    <= 1'b0;
      rep_q   <= 1'b0;
      pend_q  <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= PW'(gray_of(32'(rbin_d)));
      sym_q   <= sym_d;
      st_q    <= st_d;
      uf_q    <= uf_d;
      rep_q   <= rep_d;
      pend_q  <= pend_d;
      tgl_q   <= ovf_tgl_sync_i;
    end
  end

  assign rgray_o  = rgray_q;
  assign sym_o    = sym_q;
  assign status_o = st_q;

  // R4
  uf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UF) |-> (sym_q == SYM_UF));
  // R4
  uf_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UF) |=> (st_q != ST_UF));
  // R8
  zero_ppm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_ppm_i && rd_en_i) |=> !(st_q inside {ST_DROP, ST_INS}));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (st_q == ST_OK && $stable(sym_q)));
  // R5
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= PW'(DEPTH));
endmodule

// File: rtl/elastic_rate_match.sv
module elastic_rate_match #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_wr_i,
  input  logic          rst_wr_ni,
  input  logic          wr_en_i,
  input  logic [8:0]    wr_sym_i,
  input  logic          clk_rd_i,
  input  logic          rst_rd_ni,
  input  logic          rd_en_i,
  input  logic          zero_ppm_i,
  input  logic [PW-1:0] hi_wm_i,
  input  logic [PW-1:0] lo_wm_i,
  output logic [8:0]    rd_sym_o,
  output logic [2:0]    rd_status_o
);
  localparam logic [PW-1:0] WG_RST = PW'(rmf_pkg::gray_of(32'(DEPTH / 2)));

  logic                  wr_rst_n, rd_rst_n;
  logic [PW-1:0]         wgray, wgray_s, rgray, rgray_s;
  logic                  tgl, tgl_s;
  logic [DEPTH-1:0][8:0] mem;

  rmf_rst_sync u_wr_rst (.clk_i(clk_wr_i), .rst_ni(rst_wr_ni), .rst_no(wr_rst_n));
  rmf_rst_sync u_rd_rst (.clk_i(clk_rd_i), .rst_ni(rst_rd_ni), .rst_no(rd_rst_n));

  rmf_sync #(.W(PW), .RST_VAL('0)) u_rg_sync (
    .clk_i(clk_wr_i), .rst_ni(wr_rst_n), .d_i(rgray), .q_o(rgray_s));
  rmf_sync #(.W(PW), .RST_VAL(WG_RST)) u_wg_sync (
    .clk_i(clk_rd_i), .rst_ni(rd_rst_n), .d_i(wgray), .q_o(wgray_s));
  rmf_sync #(.W(1), .RST_VAL(1'b0)) u_ovf_sync (
    .clk_i(clk_rd_i), .rst_ni(rd_rst_n), .d_i(tgl), .q_o(tgl_s));

  rmf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(clk_wr_i), .rst_ni(wr_rst_n), .wr_en_i(wr_en_i), .wr_sym_i(wr_sym_i),
    .rgray_sync_i(rgray_s), .wgray_o(wgray), .ovf_tgl_o(tgl), .mem_o(mem));

  rmf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(clk_rd_i), .rst_ni(rd_rst_n), .rd_en_i(rd_en_i), .zero_ppm_i(zero_ppm_i),
    .hi_wm_i(hi_wm_i), .lo_wm_i(lo_wm_i), .wgray_sync_i(wgray_s),
    .ovf_tgl_sync_i(tgl_s), .mem_i(mem), .rgray_o(rgray),
    .sym_o(rd_sym_o), .status_o(rd_status_o));
endmodule

// File: tb/elastic_rate_match_tb.sv
`timescale 1ns/1ps
module elastic_rate_match_tb;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk_wr = 0, clk_rd = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, zero_ppm = 1, rd_prev = 0;
  logic [8:0] wr_sym = '0;
  logic [PW-1:0] hi_wm = PW'(12), lo_wm = PW'(3);
  logic [8:0] rd_sym;
  logic [2:0] rd_status;

  int total = 0, bad = 0;
  int n_skp = 0, n_uf = 0, n_drop = 0, n_ins = 0, n_ovf = 0, n_data = 0;
  bit prev_uf = 0;
  logic [8:0] exp_q[$];

  elastic_rate_match #(.DEPTH(DEPTH)) u_dut (
    .clk_wr_i(clk_wr), .rst_wr_ni(rst_n), .wr_en_i(wr_en), .wr_sym_i(wr_sym),
    .clk_rd_i(clk_rd), .rst_rd_ni(rst_n), .rd_en_i(rd_en), .zero_ppm_i(zero_ppm),
    .hi_wm_i(hi_wm), .lo_wm_i(lo_wm), .rd_sym_o(rd_sym), .rd_status_o(rd_status));

  always #10 clk_wr = ~clk_wr;
  initial begin
    #3;
    forever #10 clk_rd = ~clk_rd;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one symbol per write-clock cycle, data pushed to the scoreboard
  task automatic put(input logic [8:0] s, input bit keep);
    @(negedge clk_wr);
    wr_en  = 1;
    wr_sym = s;
    if (keep && !s[8]) exp_q.push_back(s);
  endtask
  task automatic wr_idle(input int n);
    @(negedge clk_wr);
    wr_en = 0;
    repeat (n) @(negedge clk_wr);
  endtask
  task automatic rd_run(input int n);
    @(negedge clk_rd);
    rd_en = 1;
    repeat (n) @(negedge clk_rd);
    rd_en = 0;
    repeat (2) @(negedge clk_rd);
  endtask

  always @(posedge clk_rd) rd_prev <= rd_en;

  // monitor
  always @(negedge clk_rd) begin
    if (rst_n && rd_prev) begin
      if (rd_sym == 9'h1FE) begin
        check(rd_status == (prev_uf ? 3'b000 : 3'b110), "R3 underflow status",
              rd_status, prev_uf ? 0 : 6);
        if (rd_status == 3'b110) n_uf++;
        prev_uf = 1;
      end else begin
        prev_uf = 0;
        if (rd_status == 3'b110) check(0, "R4 underflow code on non-1FE", rd_sym, 9'h1FE);
        if (!rd_sym[8]) begin
          logic [8:0] e;
          n_data++;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
          check(rd_sym == e, "R1 data order", rd_sym, e);
          check(rd_status inside {3'b000, 3'b010, 3'b101}, "R10 data status", rd_status, 0);
          if (rd_status == 3'b101) n_ovf++;
          if (rd_status == 3'b010) n_drop++;
        end else begin
          if (rd_sym == 9'h11C) n_skp++;
          if (rd_status == 3'b001) n_ins++;
          check(rd_status inside {3'b000, 3'b001, 3'b101}, "R10 control status", rd_status, 0);
        end
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, d0, i0, u0, o0;
    logic [8:0] held;
    repeat (5) @(negedge clk_rd);
    rst_n = 1;
    repeat (5) @(negedge clk_rd);
    // R2 reset outputs
    check(rd_sym == 9'h11C, "R2 reset symbol", rd_sym, 9'h11C);
    check(rd_status == 3'b000, "R2 reset status", rd_status, 0);

    // R2/R3 prefill drains, then one underflow
    rd_run(12);
    check(n_skp == DEPTH / 2, "R2 prefill skip count", n_skp, DEPTH / 2);
    check(n_uf == 1, "R3 single underflow", n_uf, 1);

    // R9 idle hold
    held = rd_sym;
    repeat (3) begin
      @(negedge clk_rd);
      check(rd_sym == held && rd_status == 3'b000, "R9 idle hold", rd_sym, held);
    end

    // R1 streaming in zero-ppm mode with a gap
    fork
      begin
        rd_run(60);
      end
      begin
        for (int k = 0; k < 10; k++) put(9'(8'h20 + k), 1);
        wr_idle(20);
        for (int k = 0; k < 5; k++) put(9'(8'h40 + k), 1);
        wr_idle(2);
      end
    join
    check(exp_q.size() == 0, "R1 stream drained", exp_q.size(), 0);
    check(n_uf == 3, "R3 underflow per gap", n_uf, 3);

    // R8 zero-ppm: thresholds set to trigger but no compensation
    hi_wm = PW'(2); lo_wm = PW'(14);
    for (int k = 0; k < 10; k++) put((k % 2 == 0) ? 9'h11C : 9'(8'h60 + k), 1);
    wr_idle(10);
    s0 = n_skp; d0 = n_drop; i0 = n_ins;
    rd_run(20);
    check(n_skp - s0 == 5, "R8 skips preserved", n_skp - s0, 5);
    check(n_drop == d0 && n_ins == i0, "R8 no add/drop", n_drop - d0 + n_ins - i0, 0);

    // R6 drop above high mark
    zero_ppm = 0; hi_wm = PW'(10); lo_wm = PW'(0);
    for (int k = 0; k < 14; k++) put((k % 2 == 0) ? 9'h11C : 9'(8'h80 + k), 1);
    wr_idle(10);
    s0 = n_skp; d0 = n_drop;
    rd_run(20);
    check(n_drop - d0 == 2, "R6 drop count", n_drop - d0, 2);
    check(n_skp - s0 == 5, "R6 skips left", n_skp - s0, 5);

    // R7 repeat below low mark
    hi_wm = PW'(15); lo_wm = PW'(3);
    s0 = n_skp; i0 = n_ins;
    fork
      begin
        rd_run(50);
      end
      begin
        put(9'h11C, 1); wr_idle(10);
        put(9'h0A5, 1); wr_idle(10);
        put(9'h11C, 1); wr_idle(10);
      end
    join
    check(n_ins - i0 == 2, "R7 insert count", n_ins - i0, 2);
    check(n_skp - s0 == 4, "R7 skips doubled", n_skp - s0, 4);

    // R5 overflow: one write beyond full is discarded
    zero_ppm = 1;
    repeat (5) @(negedge clk_rd);
    for (int k = 0; k < DEPTH + 1; k++) put(9'(8'hC0 + k), k < DEPTH);
    wr_idle(10);
    o0 = n_ovf; u0 = n_uf; d0 = n_data;
    rd_run(25);
    check(n_ovf - o0 == 1, "R5 overflow reported once", n_ovf - o0, 1);
    check(n_data - d0 == DEPTH, "R5 discarded write", n_data - d0, DEPTH);
    check(n_uf - u0 == 1, "R3 underflow after full drain", n_uf - u0, 1);
    check(exp_q.size() == 0, "R1 nothing lost", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule